// File: doc/BRIEF.md
# Multi-Context Receive DMA Sequencer

This block drains a small receive packet store into host buffers on behalf of several contexts. Arriving packets are described by a length and a few status bits and placed in in-order slots. A context hands the block one buffer at a time: a buffer address and a buffer length. The sequencer binds the context to the oldest packet no one has claimed yet, copies as much of that packet as the buffer holds through a single request/done DMA port, and reports a completion word for that context.

A packet may be larger than one buffer. The context then keeps ownership of the packet, and its next buffer continues the packet at the advanced offset. Contexts that continue a packet are always served ahead of contexts that are waiting for a fresh one. The buffer address value 1 is reserved: it consumes the bytes without any transfer on the DMA port. Each completion pulses a receive-DMA event. Freeing the last stored packet also pulses a receive-empty event. A level signal with hysteresis reports when the store is running low.

Top module: `rx_dma_seq`

## Requirements
- R1: After reset no context is busy, the store holds nothing, `pkt_full`, `dma_req`, `done_valid` and both event outputs are low, and `rx_low` is high.
- R2: A request to a context that is not busy is accepted and sets that context's busy bit on the next cycle. A request to a busy context raises `req_err` in the same cycle and is otherwise ignored. The busy bit clears on the cycle after that context's completion.
- R3: While any context that already owns a partly copied packet waits with a buffer, it is served before any context waiting for a fresh packet. Within each group, service is in order of request.
- R4: A context waiting for a fresh packet is served only when a stored, unclaimed packet exists, and packets are claimed in arrival order. `dma_slot` names the claimed slot.
- R5: The copy length presented on `dma_len` is the smaller of the buffer length and the bytes still unread in the packet.
- R6: A buffer address of 1 produces no `dma_req` and leads to the completion as if the copy had been done.
- R7: The completion word has bit `DW-1` = complete (always 1), bit `LEN_W+STAT_W` = more, bits `[LEN_W+STAT_W-1:LEN_W]` = the packet's status bits, and bits `[LEN_W-1:0]` = a length. On a partial copy, more is 1, the length is the bytes still left, and the next copy for that packet starts at `dma_off` advanced by the copied length.
- R8: On a final copy, more is 0, the length is the bytes copied, and the packet's slot is freed, so `fifo_level` drops by one on the next cycle.
- R9: `dma_req` rises only in a cycle after `dma_port_busy` was low. It then stays high with address, length and offset unchanged until `dma_done`.
- R10: Every completion pulses `irq_rx_dma` together with `done_valid`. The completion that frees the only stored packet, in a cycle with no accepted push, also pulses `irq_rx_empty`.
- R11: `rx_low` sets when `fifo_level` is below `LOW_MARK` and clears when it is above `HIGH_MARK`. Between the two it holds, one cycle behind the level.
- R12: Slots are filled in a circular order. `pkt_full` is high while the slot at the write position is still held. A push in that condition is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_push | input | 1 | A packet arrives this cycle |
| pkt_len | input | LEN_W | Byte length of the arriving packet (nonzero) |
| pkt_stat | input | STAT_W | Type and status bits of the arriving packet |
| pkt_full | output | 1 | Slot at the write position is occupied |
| req_wr | input | 1 | A context posts a buffer |
| req_ctx | input | $clog2(NCTX) | Posting context |
| req_addr | input | ADDR_W | Buffer address (1 = discard) |
| req_len | input | LEN_W | Buffer length |
| req_err | output | 1 | The posting context was still busy |
| ctx_busy | output | NCTX | Per-context busy bits |
| dma_req | output | 1 | DMA write request, held until done |
| dma_addr | output | ADDR_W | Destination buffer address |
| dma_len | output | LEN_W | Bytes to copy |
| dma_slot | output | $clog2(SLOTS) | Source packet slot |
| dma_off | output | LEN_W | Byte offset inside the packet |
| dma_port_busy | input | 1 | Shared DMA port is occupied by another user |
| dma_done | input | 1 | The current DMA has finished |
| done_valid | output | 1 | Completion word valid |
| done_ctx | output | $clog2(NCTX) | Context the completion belongs to |
| done_word | output | LEN_W+STAT_W+2 | Completion word |
| irq_rx_dma | output | 1 | Receive-DMA event pulse |
| irq_rx_empty | output | 1 | Store became empty |
| rx_low | output | 1 | Store occupancy low, with hysteresis |
| fifo_level | output | $clog2(SLOTS+1) | Stored packet count |

## Verification
The bench builds the block with four contexts, four packet slots, a low mark of 1 and a high threshold of 2. With these values a handful of packets is enough to fill the store and drop a push. The same few packets wrap both slot pointers and cross each hysteresis edge in both directions. Four contexts are enough to queue a continuing request behind a fresh one while the DMA port is held busy, so the priority order shows up in the completion sequence.

// File: rtl/rx_dma_seq.sv
module rx_dma_seq #(
  parameter int NCTX      = 4,
  parameter int SLOTS     = 4,
  parameter int LEN_W     = 12,
  parameter int ADDR_W    = 16,
  parameter int STAT_W    = 4,
  parameter int LOW_MARK  = 1,
  parameter int HIGH_MARK = 2,
  localparam int CW = $clog2(NCTX),
  localparam int SW = $clog2(SLOTS),
  localparam int QW = $clog2(NCTX + 1),
  localparam int LW = $clog2(SLOTS + 1),
  localparam int DW = LEN_W + STAT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_push,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [STAT_W-1:0] pkt_stat,
  output logic              pkt_full,
  input  logic              req_wr,
  input  logic [CW-1:0]     req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_err,
  output logic [NCTX-1:0]   ctx_busy,
  output logic              dma_req,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic [SW-1:0]     dma_slot,
  output logic [LEN_W-1:0]  dma_off,
  input  logic              dma_port_busy,
  input  logic              dma_done,
  output logic              done_valid,
  output logic [CW-1:0]     done_ctx,
  output logic [DW-1:0]     done_word,
  output logic              irq_rx_dma,
  output logic              irq_rx_empty,
  output logic              rx_low,
  output logic [LW-1:0]     fifo_level
);

  typedef enum logic [2:0] {S_IDLE, S_FBLK, S_BEGIN, S_COPY, S_DONE} st_t;
  st_t st;

  logic [SLOTS-1:0]  s_vld, s_asg;
  logic [LEN_W-1:0]  s_len  [SLOTS];
  logic [STAT_W-1:0] s_stat [SLOTS];
  logic [SW-1:0]     wp, rp;
  logic [LW-1:0]     level;
  logic              low_q;

  logic [NCTX-1:0]   busy, own;
  logic [SW-1:0]     c_slot [NCTX];
  logic [LEN_W-1:0]  c_off  [NCTX];
  logic [LEN_W-1:0]  c_rem  [NCTX];
  logic [LEN_W-1:0]  c_blen [NCTX];
  logic [ADDR_W-1:0] c_addr [NCTX];
  logic [STAT_W-1:0] c_stat [NCTX];
  logic [CW-1:0]     act;

  logic [CW-1:0] cq [NCTX];
  logic [CW-1:0] nq [NCTX];
  logic [CW-1:0] cq_rd, cq_wr, nq_rd, nq_wr;
  logic [QW-1:0] cq_n, nq_n;

  function automatic logic [CW-1:0] nxt_c(input logic [CW-1:0] p);
    return (p == CW'(NCTX - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [SW-1:0] nxt_s(input logic [SW-1:0] p);
    return (p == SW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  wire push_ok = pkt_push && !s_vld[wp];
  wire req_ok  = req_wr && !busy[req_ctx];
  wire push_c  = req_ok && own[req_ctx];
  wire push_n  = req_ok && !own[req_ctx];
  wire fresh   = s_vld[rp] && !s_asg[rp];
  wire take_c  = (st == S_FBLK) && (cq_n != '0);
  wire take_n  = (st == S_FBLK) && (cq_n == '0) && (nq_n != '0) && fresh;
  wire [CW-1:0] pick = take_c ? cq[cq_rd] : nq[nq_rd];

  wire [LEN_W-1:0] cp_len = (c_blen[act] < c_rem[act]) ? c_blen[act] : c_rem[act];
  wire last     = (cp_len == c_rem[act]);
  wire skip     = (c_addr[act] == ADDR_W'(1));
  wire fin_free = (st == S_DONE) && last;
  wire q_empty  = (cq_n == '0) && (nq_n == '0);

  assign pkt_full     = s_vld[wp];
  assign req_err      = req_wr && busy[req_ctx];
  assign ctx_busy     = busy;
  assign dma_req      = (st == S_COPY);
  assign dma_addr     = c_addr[act];
  assign dma_len      = cp_len;
  assign dma_slot     = c_slot[act];
  assign dma_off      = c_off[act];
  assign done_valid   = (st == S_DONE);
  assign done_ctx     = act;
  assign done_word    = {1'b1, ~last, c_stat[act], last ? cp_len : (c_rem[act] - cp_len)};
  assign irq_rx_dma   = (st == S_DONE);
  assign irq_rx_empty = fin_free && (level == LW'(1)) && !push_ok;
  assign rx_low       = low_q;
  assign fifo_level   = level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      act <= '0;
    end else begin
      case (st)
        S_IDLE:  if (!q_empty) st <= S_FBLK;
        S_FBLK:  if (take_c || take_n) begin
                   act <= pick;
                   st  <= S_BEGIN;
                 end
        S_BEGIN: if (skip) st <= S_DONE;
                 else if (!dma_port_busy) st <= S_COPY;
        S_COPY:  if (dma_done) st <= S_DONE;
        S_DONE:  st <= q_empty ? S_IDLE : S_FBLK;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq_rd <= '0; cq_wr <= '0; cq_n <= '0;
      nq_rd <= '0; nq_wr <= '0; nq_n <= '0;
    end else begin
      if (push_c) cq_wr <= nxt_c(cq_wr);
      if (take_c) cq_rd <= nxt_c(cq_rd);
      cq_n <= cq_n + QW'(push_c) - QW'(take_c);
      if (push_n) nq_wr <= nxt_c(nq_wr);
      if (take_n) nq_rd <= nxt_c(nq_rd);
      nq_n <= nq_n + QW'(push_n) - QW'(take_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push_c) cq[cq_wr] <= req_ctx;
    if (push_n) nq[nq_wr] <= req_ctx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld <= '0;
      s_asg <= '0;
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      low_q <= 1'b1;
    end else begin
      if (push_ok) begin
        s_vld[wp] <= 1'b1;
        s_asg[wp] <= 1'b0;
        wp        <= nxt_s(wp);
      end
      if (take_n) begin
        s_asg[rp] <= 1'b1;
        rp        <= nxt_s(rp);
      end
      if (fin_free) begin
        s_vld[c_slot[act]] <= 1'b0;
        s_asg[c_slot[act]] <= 1'b0;
      end
      level <= level + LW'(push_ok) - LW'(fin_free);
      if (int'(level) < LOW_MARK) low_q <= 1'b1;
      else if (int'(level) > HIGH_MARK) low_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      s_len[wp]  <= pkt_len;
      s_stat[wp] <= pkt_stat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      own  <= '0;
    end else begin
      if (req_ok) busy[req_ctx] <= 1'b1;
      if (take_n) own[pick] <= 1'b1;
      if (st == S_DONE) begin
        busy[act] <= 1'b0;
        if (last) own[act] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (req_ok) begin
      c_addr[req_ctx] <= req_addr;
      c_blen[req_ctx] <= req_len;
    end
    if (take_n) begin
      c_slot[pick] <= rp;
      c_off[pick]  <= '0;
      c_rem[pick]  <= s_len[rp];
      c_stat[pick] <= s_stat[rp];
    end
    if ((st == S_DONE) && !last) begin
      c_off[act] <= c_off[act] + cp_len;
      c_rem[act] <= c_rem[act] - cp_len;
    end
  end

  // R9
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_done |=> dma_req && $stable(dma_addr) && $stable(dma_len) && $stable(dma_off));

  // R9
  dma_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> !$past(dma_port_busy));

  // R6
  dma_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_addr != ADDR_W'(1));

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr && !ctx_busy[req_ctx] |=> ctx_busy[$past(req_ctx)]);

  // R2
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !ctx_busy[$past(done_ctx)]);

  // R3
  q_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_c |-> int'(cq_n) < NCTX) and (push_n |-> int'(nq_n) < NCTX));

  // R8
  level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= SLOTS);

  // R10
  empty_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_empty |=> fifo_level == '0);

endmodule

// File: tb/rx_dma_seq_tb.sv
`timescale 1ns/1ps
module rx_dma_seq_tb_top;
  localparam int NC = 4, SL = 4, LNW = 12, AW = 16, STW = 4, LOWM = 1, HIGHM = 2;
  localparam int CW = $clog2(NC), SW = $clog2(SL), LVW = $clog2(SL + 1), DW = LNW + STW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_push = 0; logic [LNW-1:0] pkt_len = 0; logic [STW-1:0] pkt_stat = 0;
  logic req_wr = 0; logic [CW-1:0] req_ctx = 0; logic [AW-1:0] req_addr = 0; logic [LNW-1:0] req_len = 0;
  logic dma_port_busy = 0, dma_done = 0;
  logic pkt_full, req_err, dma_req, done_valid, irq_rx_dma, irq_rx_empty, rx_low;
  logic [NC-1:0] ctx_busy; logic [AW-1:0] dma_addr; logic [LNW-1:0] dma_len, dma_off;
  logic [SW-1:0] dma_slot; logic [CW-1:0] done_ctx; logic [DW-1:0] done_word; logic [LVW-1:0] fifo_level;

  always #2.5 clk = ~clk;

  rx_dma_seq #(.NCTX(NC), .SLOTS(SL), .LEN_W(LNW), .ADDR_W(AW), .STAT_W(STW),
               .LOW_MARK(LOWM), .HIGH_MARK(HIGHM)) dut_i (
    .clk, .rst_n, .pkt_push, .pkt_len, .pkt_stat, .pkt_full,
    .req_wr, .req_ctx, .req_addr, .req_len, .req_err, .ctx_busy,
    .dma_req, .dma_addr, .dma_len, .dma_slot, .dma_off, .dma_port_busy, .dma_done,
    .done_valid, .done_ctx, .done_word, .irq_rx_dma, .irq_rx_empty, .rx_low, .fifo_level);

  int checks = 0, errors = 0, cycles = 0, dma_lat = 1, lat_cnt = 0;
  bit finished = 0;

  // behavioural reference: 0 idle, 1 wait packet, 2 begin, 3 copy, 4 done
  int m_st, m_act, m_wp, m_rp, m_lvl;
  bit m_low;
  int m_cq[$], m_nq[$];
  bit m_busy[NC], m_own[NC];
  int m_slot[NC], m_off[NC], m_rem[NC], m_addr[NC], m_blen[NC], m_stat[NC];
  bit m_sv[SL], m_sa[SL];
  int m_len[SL], m_pst[SL];

  task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act_v, exp_v, cycles);
    end
  endtask

  function automatic int mcp();
    return (m_blen[m_act] < m_rem[m_act]) ? m_blen[m_act] : m_rem[m_act];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = 0; m_act = 0; m_wp = 0; m_rp = 0; m_lvl = 0; m_low = 1;
      m_cq.delete(); m_nq.delete();
      for (int i = 0; i < NC; i++) begin m_busy[i] = 0; m_own[i] = 0; end
      for (int i = 0; i < SL; i++) begin m_sv[i] = 0; m_sa[i] = 0; end
    end else begin
      int old_lvl, ns, c, cp;
      bit pok, rok;
      old_lvl = m_lvl;
      pok = pkt_push && !m_sv[m_wp];
      rok = req_wr && !m_busy[req_ctx];
      ns = m_st;
      case (m_st)
        0: if (m_cq.size() != 0 || m_nq.size() != 0) ns = 1;
        1: if (m_cq.size() != 0) begin
             m_act = m_cq.pop_front(); ns = 2;
           end else if (m_nq.size() != 0 && m_sv[m_rp] && !m_sa[m_rp]) begin
             c = m_nq.pop_front(); m_act = c; m_own[c] = 1; m_slot[c] = m_rp;
             m_off[c] = 0; m_rem[c] = m_len[m_rp]; m_stat[c] = m_pst[m_rp];
             m_sa[m_rp] = 1; m_rp = (m_rp + 1) % SL; ns = 2;
           end
        2: if (m_addr[m_act] == 1) ns = 4; else if (!dma_port_busy) ns = 3;
        3: if (dma_done) ns = 4;
        4: begin
             cp = mcp();
             if (cp == m_rem[m_act]) begin
               m_own[m_act] = 0; m_sv[m_slot[m_act]] = 0; m_sa[m_slot[m_act]] = 0; m_lvl--;
             end else begin
               m_off[m_act] += cp; m_rem[m_act] -= cp;
             end
             m_busy[m_act] = 0;
             ns = (m_cq.size() == 0 && m_nq.size() == 0) ? 0 : 1;
           end
        default: ns = 0;
      endcase
      if (pok) begin
        m_sv[m_wp] = 1; m_sa[m_wp] = 0; m_len[m_wp] = pkt_len; m_pst[m_wp] = pkt_stat;
        m_wp = (m_wp + 1) % SL; m_lvl++;
      end
      if (rok) begin
        m_busy[req_ctx] = 1; m_addr[req_ctx] = req_addr; m_blen[req_ctx] = req_len;
        if (m_own[req_ctx]) m_cq.push_back(req_ctx); else m_nq.push_back(req_ctx);
      end
      if (old_lvl < LOWM) m_low = 1; else if (old_lvl > HIGHM) m_low = 0;
      m_st = ns;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    int cp, rest;
    bit fin;
    logic [DW-1:0] ew;
    chk(pkt_full == m_sv[m_wp], "R12 pkt_full", pkt_full, m_sv[m_wp]);
    chk(fifo_level == LVW'(m_lvl), "R8 fifo_level", fifo_level, m_lvl);
    chk(rx_low == m_low, "R11 rx_low", rx_low, m_low);
    for (int i = 0; i < NC; i++) chk(ctx_busy[i] == m_busy[i], "R2 ctx_busy", ctx_busy[i], m_busy[i]);
    chk(req_err == (req_wr && m_busy[req_ctx]), "R2 req_err", req_err, req_wr && m_busy[req_ctx]);
    chk(dma_req == (m_st == 3), "R6 R9 dma_req", dma_req, m_st == 3);
    if (m_st == 3 && dma_req) begin
      cp = mcp();
      chk(dma_addr == AW'(m_addr[m_act]), "R9 dma_addr", dma_addr, m_addr[m_act]);
      chk(dma_len == LNW'(cp), "R5 dma_len", dma_len, cp);
      chk(dma_slot == SW'(m_slot[m_act]), "R4 dma_slot", dma_slot, m_slot[m_act]);
      chk(dma_off == LNW'(m_off[m_act]), "R7 dma_off", dma_off, m_off[m_act]);
    end
    chk(done_valid == (m_st == 4), "R10 done_valid", done_valid, m_st == 4);
    chk(irq_rx_dma == (m_st == 4), "R10 irq_rx_dma", irq_rx_dma, m_st == 4);
    fin = 0;
    if (m_st == 4) begin
      cp = mcp(); fin = (cp == m_rem[m_act]); rest = fin ? cp : m_rem[m_act] - cp;
      ew = {1'b1, !fin, STW'(m_stat[m_act]), LNW'(rest)};
      chk(done_ctx == CW'(m_act), "R3 done_ctx", done_ctx, m_act);
      chk(done_word == ew, "R7 R8 done_word", done_word, ew);
    end
    chk(irq_rx_empty == (m_st == 4 && fin && m_lvl == 1 && !(pkt_push && !m_sv[m_wp])),
        "R10 irq_rx_empty", irq_rx_empty, m_st == 4 && fin && m_lvl == 1);
  end

  always @(posedge clk) begin
    #1;
    if (dma_req && !dma_done) begin
      if (lat_cnt >= dma_lat) begin dma_done = 1; lat_cnt = 0; end
      else lat_cnt++;
    end else dma_done = 0;
  end

  always @(posedge clk) if (cycles > 20000 && !finished) begin
    finished = 1; errors++; checks++;
    $display("FAIL watchdog expired actual %0d expected below 20000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic push(input int len, input int st_bits);
    @(posedge clk); #1; pkt_push = 1; pkt_len = LNW'(len); pkt_stat = STW'(st_bits);
    @(posedge clk); #1; pkt_push = 0;
  endtask

  task automatic post(input int c, input int a, input int l);
    @(posedge clk); #1; req_wr = 1; req_ctx = CW'(c); req_addr = AW'(a); req_len = LNW'(l);
    @(posedge clk); #1; req_wr = 0;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (!(m_st == 0 && m_cq.size() == 0 && m_nq.size() == 0));
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ctx_busy == '0, "R1 busy", ctx_busy, 0);
    chk(fifo_level == '0, "R1 level", fifo_level, 0);
    chk(rx_low == 1'b1, "R1 rx_low", rx_low, 1);
    chk(!dma_req && !done_valid && !irq_rx_dma && !irq_rx_empty && !pkt_full, "R1 outputs", dma_req, 0);

    push(10, 3); push(25, 5); repeat (2) @(posedge clk);
    push(7, 6); repeat (3) @(posedge clk);
    post(0, 'h40, 100); wait_idle();
    post(1, 'h80, 8); wait_idle();
    dma_lat = 3;
    post(1, 'h90, 8); post(1, 'h94, 8); wait_idle();
    dma_lat = 1;
    @(posedge clk); #1; dma_port_busy = 1;
    post(3, 'h200, 50);
    post(2, 'h300, 40);
    post(1, 'h180, 4);
    repeat (4) @(posedge clk); #1; dma_port_busy = 0;
    repeat (20) @(posedge clk);
    push(12, 9); wait_idle();
    post(1, 1, 20); wait_idle();
    dma_lat = 0;
    push(5, 1); push(6, 2); push(9, 4); push(11, 8); push(13, 15);
    repeat (2) @(posedge clk);
    post(0, 'h10, 5); post(1, 'h20, 3); post(2, 'h30, 9); post(3, 1, 2);
    wait_idle();
    post(3, 'h50, 16); post(1, 'h60, 6); wait_idle();
    repeat (4) @(posedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule